// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This unit sits between instruction decode and the accumulator of a small accumulator machine. Given a mode code and the 12-bit operand field of an instruction, it works out where the operand lives and returns the word that should be loaded into the accumulator. It also returns the effective address it used. The field may be taken literally or read from a register. It may also be an address, used on its own or offset by an index or base register. In the indirect case it points to a word that is itself the address of the operand.

The unit owns a synchronous single-port word memory, written so that it maps onto block RAM. A write port lets the surrounding system fill that memory while no fetch is running. Registers are read through a combinational register-file port: the unit presents a register number and receives its contents. The index and base registers arrive as separate inputs. A request is made with a one-cycle start strobe and completes with a one-cycle done pulse. The number of cycles depends on how many memory reads the mode needs: none, one, or two chained reads.

Top module: `opfetch_unit`

## Requirements
- R1: Mode code 0 (literal) returns the operand field as the value and as the effective address. No memory is read. Done is high in the cycle that follows the clock edge that accepted start (latency 1).
- R2: Mode code 1 (absolute) returns the memory word at the operand field, with the effective address equal to the field. Latency is 2.
- R3: Mode code 2 (register) drives the low 4 bits of the field on the register-select output. It returns the register contents sampled at the accepting edge, with the effective address equal to the field. Latency is 1.
- R4: Mode code 3 (pointer) first reads the memory word at the field. It then reads memory at that word and returns the result. The effective address is the pointer word. Latency is 3.
- R5: Mode code 4 (register pointer) uses the selected register's contents as the effective address and returns the memory word there. Latency is 2.
- R6: Mode code 5 (index offset) uses field plus the index input, modulo 4096, as the effective address. Latency is 2.
- R7: Mode code 6 (base displacement) uses the base input plus the field, modulo 4096, as the effective address. Latency is 2.
- R8: The memory decodes only the low MEM_AW bits (default 10) of an address, so addresses alias every 1024 words. The effective address output still reports all 12 bits.
- R9: Mode code 7 behaves exactly like mode code 0.
- R10: Start is ignored while a fetch is in progress. A start presented in the cycle where done is high is accepted. Each accepted start gives exactly one done pulse, one cycle wide.
- R11: A memory write is performed only when the unit is idle and no start is accepted in the same cycle. A write request while busy, or alongside an accepted start, is dropped.
- R12: After reset, done, value and effective address outputs are all zero and the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Fetch request strobe |
| mode_i | input | 3 | Addressing mode code |
| field_i | input | 12 | Operand field of the instruction |
| rsel_o | output | 4 | Register number presented to the register file |
| rdata_i | input | 12 | Contents of the selected register |
| index_i | input | 12 | Index register contents |
| base_i | input | 12 | Base register contents |
| wr_en_i | input | 1 | Memory write request |
| wr_addr_i | input | 12 | Memory write address |
| wr_data_i | input | 12 | Memory write data |
| done_o | output | 1 | One-cycle completion pulse |
| value_o | output | 12 | Operand for the accumulator |
| ea_o | output | 12 | Effective address used |

## Verification
Two pairs of events can share a cycle. A new start can arrive in the cycle where the previous done is high. A memory write request can coincide with an accepted start, or arrive while a fetch is in flight. The bench provokes the first by holding start through the done cycle of an absolute fetch. It expects a second done one cycle later carrying the new literal, and also holds start through a pointer fetch to show that start is not taken mid-flight. For the write cases, it later reads the targeted word back through an absolute fetch and expects the old contents.

// File: rtl/ofu_pkg.sv
package ofu_pkg;

  typedef enum logic [2:0] {
    M_LIT  = 3'd0,
    M_ABS  = 3'd1,
    M_REG  = 3'd2,
    M_PTR  = 3'd3,
    M_RPTR = 3'd4,
    M_IDX  = 3'd5,
    M_BASE = 3'd6,
    M_RSV  = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_CHASE = 2'd1,
    S_LAND  = 2'd2
  } state_e;

endpackage

// File: rtl/ofu_ea_calc.sv
module ofu_ea_calc
  import ofu_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [2:0]   mode,
  input  logic [W-1:0] field,
  input  logic [W-1:0] reg_val,
  input  logic [W-1:0] index_val,
  input  logic [W-1:0] base_val,
  output logic [W-1:0] ea,
  output logic         use_mem,
  output logic         chained
);

  always_comb begin
    ea      = field;
    use_mem = 1'b0;
    chained = 1'b0;
    case (mode_e'(mode))
      M_ABS:  use_mem = 1'b1;
      M_PTR:  begin use_mem = 1'b1; chained = 1'b1; end
      M_RPTR: begin ea = reg_val; use_mem = 1'b1; end
      M_IDX:  begin ea = field + index_val; use_mem = 1'b1; end
      M_BASE: begin ea = base_val + field; use_mem = 1'b1; end
      default: ;
    endcase
  end

endmodule

// File: rtl/ofu_ram.sv
module ofu_ram #(
  parameter int W  = 12,
  parameter int AW = 10,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    if (en) rdata <= store[addr];
  end

endmodule

// File: rtl/ofu_ctrl.sv
module ofu_ctrl
  import ofu_pkg::*;
#(
  parameter int W   = 12,
  parameter int MAW = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [2:0]     mode,
  input  logic [W-1:0]   field,
  input  logic [W-1:0]   reg_val,
  input  logic [W-1:0]   ea_new,
  input  logic           use_mem,
  input  logic           chained,
  input  logic [W-1:0]   mem_q,
  input  logic           wr_en,
  input  logic [W-1:0]   wr_addr,
  output logic           ram_en,
  output logic           ram_we,
  output logic [MAW-1:0] ram_addr,
  output logic           done,
  output logic [W-1:0]   value,
  output logic [W-1:0]   ea_q,
  output logic           busy
);

  state_e state;
  logic   accept;

  assign accept = (state == S_IDLE) && start;
  assign busy   = (state != S_IDLE);

  // single port: fetch reads have priority, writes only in a free idle cycle
  always_comb begin
    ram_en   = 1'b0;
    ram_we   = 1'b0;
    ram_addr = wr_addr[MAW-1:0];
    case (state)
      S_IDLE: begin
        if (accept && use_mem) begin
          ram_en   = 1'b1;
          ram_addr = ea_new[MAW-1:0];
        end else if (!start && wr_en) begin
          ram_we = 1'b1;
        end
      end
      S_CHASE: begin
        ram_en   = 1'b1;
        ram_addr = mem_q[MAW-1:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      done  <= 1'b0;
      value <= '0;
      ea_q  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            ea_q <= ea_new;
            if (!use_mem) begin
              value <= (mode_e'(mode) == M_REG) ? reg_val : field;
              done  <= 1'b1;
            end else begin
              state <= chained ? S_CHASE : S_LAND;
            end
          end
        end
        S_CHASE: begin
          ea_q  <= mem_q;
          state <= S_LAND;
        end
        S_LAND: begin
          value <= mem_q;
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/opfetch_unit.sv
module opfetch_unit #(
  parameter int W      = 12,
  parameter int MEM_AW = 10,
  parameter int RSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  input  logic [W-1:0]      field_i,
  output logic [RSEL_W-1:0] rsel_o,
  input  logic [W-1:0]      rdata_i,
  input  logic [W-1:0]      index_i,
  input  logic [W-1:0]      base_i,
  input  logic              wr_en_i,
  input  logic [W-1:0]      wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  output logic              done_o,
  output logic [W-1:0]      value_o,
  output logic [W-1:0]      ea_o
);

  logic [W-1:0]      ea_new;
  logic              use_mem, chained;
  logic              ram_en, ram_we;
  logic [MEM_AW-1:0] ram_addr;
  logic [W-1:0]      mem_q;
  logic              busy_w;

  assign rsel_o = field_i[RSEL_W-1:0];

  ofu_ea_calc #(.W(W)) u_ea (
    .mode      (mode_i),
    .field     (field_i),
    .reg_val   (rdata_i),
    .index_val (index_i),
    .base_val  (base_i),
    .ea        (ea_new),
    .use_mem   (use_mem),
    .chained   (chained)
  );

  ofu_ctrl #(.W(W), .MAW(MEM_AW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start_i),
    .mode     (mode_i),
    .field    (field_i),
    .reg_val  (rdata_i),
    .ea_new   (ea_new),
    .use_mem  (use_mem),
    .chained  (chained),
    .mem_q    (mem_q),
    .wr_en    (wr_en_i),
    .wr_addr  (wr_addr_i),
    .ram_en   (ram_en),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .done     (done_o),
    .value    (value_o),
    .ea_q     (ea_o),
    .busy     (busy_w)
  );

  ofu_ram #(.W(W), .AW(MEM_AW)) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (wr_data_i),
    .rdata (mem_q)
  );

endmodule

// File: rtl/ofu_checker.sv
module ofu_checker #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic [2:0]   mode_i,
  input logic [W-1:0] field_i,
  input logic [W-1:0] rdata_i,
  input logic         busy,
  input logic         done_o,
  input logic [W-1:0] value_o,
  input logic [W-1:0] ea_o
);

  // R1 / R9: literal modes finish on the next edge with the field
  a_r1_literal: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_i && (mode_i == 3'd0 || mode_i == 3'd7))
      |=> (done_o && value_o == $past(field_i) && ea_o == $past(field_i)));

  // R3: register mode returns the register contents next cycle
  a_r3_register: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_i && mode_i == 3'd2) |=> (done_o && value_o == $past(rdata_i)));

  // R2: a memory mode never completes on the next edge
  a_r2_mem_latency: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_i && mode_i == 3'd1) |=> (!done_o && busy));

  // R10: done only when the unit has returned to idle
  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy);

  // R10: a busy cycle with no completion stays busy or completes next
  a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && start_i) |=> ($stable(value_o) || done_o));

endmodule

bind opfetch_unit ofu_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .mode_i  (mode_i),
  .field_i (field_i),
  .rdata_i (rdata_i),
  .busy    (busy_w),
  .done_o  (done_o),
  .value_o (value_o),
  .ea_o    (ea_o)
);

// File: tb/test_opfetch_unit.sv
`timescale 1ns/1ps
module test_opfetch_unit;

  localparam logic [2:0] LIT = 3'd0, ABS = 3'd1, REG = 3'd2, PTR = 3'd3,
                         RPTR = 3'd4, IDX = 3'd5, BASE = 3'd6, RSV = 3'd7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [11:0] field = '0;
  logic [3:0]  rsel;
  logic [11:0] rdata, idx = '0, bas = '0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0, wr_data = '0;
  logic        done;
  logic [11:0] value, ea;
  logic [11:0] regs [16];

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;
  assign rdata = regs[rsel];

  opfetch_unit i_opfetch_unit (
    .clk(clk), .rst(rst), .start_i(start), .mode_i(mode), .field_i(field),
    .rsel_o(rsel), .rdata_i(rdata), .index_i(idx), .base_i(bas),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .done_o(done), .value_o(value), .ea_o(ea)
  );

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_word(input logic [11:0] a, input logic [11:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_fetch(input string tag, input logic [2:0] m, input logic [11:0] f,
                              input logic [11:0] ev, input logic [11:0] eea, input int elat);
    int lat;
    @(negedge clk);
    start = 1'b1; mode = m; field = f;
    lat = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end while (!done && lat < 8);
    chk({tag, " latency"}, 12'(lat), 12'(elat));
    chk({tag, " value"}, value, ev);
    chk({tag, " ea"}, ea, eea);
  endtask

  task automatic t_reset;
    chk("R12 done after reset", {11'd0, done}, 12'd0);
    chk("R12 value after reset", value, 12'd0);
    chk("R12 ea after reset", ea, 12'd0);
  endtask

  task automatic t_literal;
    expect_fetch("R1 literal", LIT, 12'h5A3, 12'h5A3, 12'h5A3, 1);
    expect_fetch("R9 reserved as literal", RSV, 12'h0C7, 12'h0C7, 12'h0C7, 1);
  endtask

  task automatic t_register;
    expect_fetch("R3 register", REG, 12'hA03, 12'h777, 12'hA03, 1);
  endtask

  task automatic t_absolute;
    expect_fetch("R2 absolute", ABS, 12'h040, 12'h0AB, 12'h040, 2);
    expect_fetch("R8 alias", ABS, 12'h410, 12'h9C9, 12'h410, 2);
  endtask

  task automatic t_pointer;
    expect_fetch("R4 pointer", PTR, 12'h050, 12'h321, 12'h060, 3);
  endtask

  task automatic t_reg_pointer;
    expect_fetch("R5 register pointer", RPTR, 12'h005, 12'h444, 12'h070, 2);
  endtask

  task automatic t_indexed;
    idx = 12'h005;
    expect_fetch("R6 index", IDX, 12'h070, 12'h555, 12'h075, 2);
    idx = 12'h020;
    expect_fetch("R6 index wrap", IDX, 12'hFF0, 12'h9C9, 12'h010, 2);
  endtask

  task automatic t_based;
    bas = 12'h100;
    expect_fetch("R7 base", BASE, 12'h010, 12'h666, 12'h110, 2);
    bas = 12'hFF8;
    expect_fetch("R7 base wrap", BASE, 12'h018, 12'h9C9, 12'h010, 2);
  endtask

  task automatic t_start_ignored;
    @(negedge clk);
    start = 1'b1; mode = PTR; field = 12'h050;
    @(negedge clk);
    mode = LIT; field = 12'h111;
    chk("R10 no done mid pointer 1", {11'd0, done}, 12'd0);
    @(negedge clk);
    chk("R10 no done mid pointer 2", {11'd0, done}, 12'd0);
    @(negedge clk);
    start = 1'b0;
    chk("R10 pointer done", {11'd0, done}, 12'd1);
    chk("R10 pointer value kept", value, 12'h321);
    @(negedge clk);
    chk("R10 start during fetch ignored", {11'd0, done}, 12'd0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    start = 1'b1; mode = ABS; field = 12'h040;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R10 first done", {11'd0, done}, 12'd1);
    chk("R10 first value", value, 12'h0AB);
    start = 1'b1; mode = LIT; field = 12'h2B2;
    @(negedge clk);
    start = 1'b0;
    chk("R10 start in done cycle taken", {11'd0, done}, 12'd1);
    chk("R10 second value", value, 12'h2B2);
    @(negedge clk);
    chk("R10 single pulse", {11'd0, done}, 12'd0);
  endtask

  task automatic t_write_busy;
    @(negedge clk);
    start = 1'b1; mode = ABS; field = 12'h040;
    @(negedge clk);
    start = 1'b0;
    wr_en = 1'b1; wr_addr = 12'h040; wr_data = 12'hEEE;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R11 fetch done", {11'd0, done}, 12'd1);
    expect_fetch("R11 write while busy dropped", ABS, 12'h040, 12'h0AB, 12'h040, 2);
  endtask

  task automatic t_write_with_start;
    write_word(12'h030, 12'h0AA);
    @(negedge clk);
    start = 1'b1; mode = LIT; field = 12'h005;
    wr_en = 1'b1; wr_addr = 12'h030; wr_data = 12'h123;
    @(negedge clk);
    start = 1'b0; wr_en = 1'b0;
    chk("R11 start wins", value, 12'h005);
    expect_fetch("R11 write with start dropped", ABS, 12'h030, 12'h0AA, 12'h030, 2);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 12'(i * 17);
    regs[3] = 12'h777;
    regs[5] = 12'h070;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    write_word(12'h040, 12'h0AB);
    write_word(12'h050, 12'h060);
    write_word(12'h060, 12'h321);
    write_word(12'h070, 12'h444);
    write_word(12'h075, 12'h555);
    write_word(12'h110, 12'h666);
    write_word(12'h010, 12'h9C9);
    t_literal();
    t_register();
    t_absolute();
    t_pointer();
    t_reg_pointer();
    t_indexed();
    t_based();
    t_start_ignored();
    t_back_to_back();
    t_write_busy();
    t_write_with_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule